// File: doc/BRIEF.md
# Ethernet carrier sense and collision generator

This block drives the carrier-sense and collision indications that a PHY presents to a MAC or repeater. Receive activity comes from one of two sources picked by the speed control. At 100 Mb/s it is derived from the serial stream of received code bits. At 10 Mb/s it is taken from an unsquelched receive-activity input. Carrier sense and collision are then formed from that activity, the MAC transmit enable, and the duplex and repeater mode controls.

At 100 Mb/s the last `WIN_W` code bits, 10 by default, are kept in a sliding window. A code bit enters the window only on a cycle where its valid strobe is high. Activity is declared when the window holds two zeros with at least one bit between them. Activity is then held until a window made only of ones has been seen. A separate SQE-test request produces a collision pulse of fixed length. That pulse can be suppressed by an inhibit control, and the request is not acted on in full-duplex mode. The outputs are formed combinationally from registered state and the mode inputs, so they need not line up with any receive or transmit clock.

Top module: `crs_col_gen`

## Requirements
- R1: While `rst_ni` is low and after its release, `crs_o` and `col_o` are low, and the code-bit window holds all ones (idle).
- R2: With `speed100_i`=1, receive activity becomes 1 one clock after the window (the last `WIN_W` bits accepted with `code_bit_vld_i`=1) contains two zeros whose positions differ by 2 or more. A window whose zeros are absent, single, or exactly two and adjacent does not raise activity.
- R3: Once raised, 100 Mb/s activity stays at 1 until the window is all ones, and it drops one clock after that idle window is formed.
- R4: With `speed100_i`=0, receive activity equals `rx_act10_i`. With `speed100_i`=1, `rx_act10_i` has no effect.
- R5: With `full_duplex_i`=0 and `repeater_i`=0, `crs_o` = receive activity OR `tx_en_i`.
- R6: With `full_duplex_i`=1 or `repeater_i`=1, `crs_o` equals receive activity only.
- R7: With `full_duplex_i`=0, `col_o` is 1 whenever receive activity and `tx_en_i` are both 1.
- R8: With `full_duplex_i`=1, `col_o` is 0 at all times. An `sqe_req_i` pulse seen in full duplex is dropped and does not show up after switching to half duplex.
- R9: An `sqe_req_i` pulse in half duplex drives `col_o` high for exactly `SQE_LEN` clocks, starting the clock after the request is sampled.
- R10: With `sqe_inhibit_i`=1, the SQE-test pulse does not reach `col_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (recovered code-bit clock domain) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| speed100_i | input | 1 | 1 selects 100 Mb/s code-bit activity, 0 selects 10 Mb/s input |
| code_bit_i | input | 1 | Received code bit |
| code_bit_vld_i | input | 1 | Code bit strobe; shifts the window when 1 |
| rx_act10_i | input | 1 | Unsquelched 10 Mb/s receive activity |
| tx_en_i | input | 1 | MAC transmit enable |
| full_duplex_i | input | 1 | 1 = full duplex |
| repeater_i | input | 1 | 1 = repeater mode |
| sqe_req_i | input | 1 | SQE-test request pulse |
| sqe_inhibit_i | input | 1 | Suppresses the SQE-test collision pulse |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision |

## Verification
All 1024 ten-bit windows are shifted in from idle. Each result is compared with a rule worked out in the bench from the zero count and from zero adjacency, which separates single zeros, adjacent pairs and spaced pairs. A zero followed by a run of ones checks that activity holds at nine ones, is still high on the cycle the idle window forms, and drops one cycle later. All 16 combinations of receive activity, transmit enable, duplex and repeater mode are swept against the carrier and collision rules. SQE requests are tried in half duplex, with inhibit set, and in full duplex followed by a switch to half duplex. This checks the pulse length and that a dropped request is not remembered.

// File: rtl/crs_col_pkg.sv
package crs_col_pkg;
  localparam int unsigned WIN_W_DEF   = 10;
  localparam int unsigned SQE_LEN_DEF = 10;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/act_window_det.sv
module act_window_det #(
  parameter int unsigned WIN_W = crs_col_pkg::WIN_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic act_o,
  output logic idle_o
);
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-3:0] pair_hit;
  logic             spaced_zeros;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        win_q <= '1;
    else if (bit_vld_i) win_q <= {win_q[WIN_W-2:0], bit_i};
  end

  // zero at i with another zero at least two positions above it
  for (genvar i = 0; i < WIN_W - 2; i++) begin : g_pair
    assign pair_hit[i] = ~win_q[i] & ~(&win_q[WIN_W-1:i+2]);
  end

  assign spaced_zeros = |pair_hit;
  assign idle_o       = &win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           act_q <= 1'b0;
    else if (spaced_zeros) act_q <= 1'b1;
    else if (idle_o)       act_q <= 1'b0;
  end

  assign act_o = act_q;
endmodule

// File: rtl/sqe_pulse_gen.sv
module sqe_pulse_gen #(
  parameter int unsigned SQE_LEN = crs_col_pkg::SQE_LEN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic en_i,
  output logic pulse_o
);
  localparam int unsigned CW = crs_col_pkg::cnt_width(SQE_LEN);
  localparam logic [CW-1:0] LEN_V = CW'(SQE_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (req_i && en_i) cnt_q <= LEN_V;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/crs_col_rules.sv
module crs_col_rules (
  input  logic rx_act_i,
  input  logic tx_en_i,
  input  logic full_duplex_i,
  input  logic repeater_i,
  input  logic sqe_i,
  input  logic sqe_inhibit_i,
  output logic crs_o,
  output logic col_o
);
  logic tx_sense;

  assign tx_sense = tx_en_i & ~full_duplex_i & ~repeater_i;
  assign crs_o    = rx_act_i | tx_sense;
  assign col_o    = ~full_duplex_i & ((rx_act_i & tx_en_i) | (sqe_i & ~sqe_inhibit_i));
endmodule

// File: rtl/crs_col_gen.sv
module crs_col_gen #(
  parameter int unsigned WIN_W   = crs_col_pkg::WIN_W_DEF,
  parameter int unsigned SQE_LEN = crs_col_pkg::SQE_LEN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic speed100_i,
  input  logic code_bit_i,
  input  logic code_bit_vld_i,
  input  logic rx_act10_i,
  input  logic tx_en_i,
  input  logic full_duplex_i,
  input  logic repeater_i,
  input  logic sqe_req_i,
  input  logic sqe_inhibit_i,
  output logic crs_o,
  output logic col_o
);
  logic act100;
  logic win_idle;
  logic rx_act;
  logic sqe_pulse;

  act_window_det #(.WIN_W(WIN_W)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (code_bit_vld_i),
    .bit_i     (code_bit_i),
    .act_o     (act100),
    .idle_o    (win_idle)
  );

  assign rx_act = speed100_i ? act100 : rx_act10_i;

  sqe_pulse_gen #(.SQE_LEN(SQE_LEN)) u_sqe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (sqe_req_i),
    .en_i    (~full_duplex_i),
    .pulse_o (sqe_pulse)
  );

  crs_col_rules u_rules (
    .rx_act_i      (rx_act),
    .tx_en_i       (tx_en_i),
    .full_duplex_i (full_duplex_i),
    .repeater_i    (repeater_i),
    .sqe_i         (sqe_pulse),
    .sqe_inhibit_i (sqe_inhibit_i),
    .crs_o         (crs_o),
    .col_o         (col_o)
  );
endmodule

// File: rtl/crs_col_chk.sv
module crs_col_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic full_duplex_i,
  input logic repeater_i,
  input logic tx_en_i,
  input logic sqe_req_i,
  input logic sqe_inhibit_i,
  input logic crs_o,
  input logic col_o,
  input logic rx_act,
  input logic act100,
  input logic win_idle
);
  assert_idle_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_idle |=> !act100);

  assert_half_tx_crs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && !repeater_i && tx_en_i) |-> crs_o);

  assert_rx_only_crs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((full_duplex_i || repeater_i) && !rx_act) |-> !crs_o);

  assert_rx_tx_col_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && rx_act && tx_en_i) |-> col_o);

  assert_fd_no_col_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_duplex_i |-> !col_o);

  assert_sqe_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sqe_req_i && !full_duplex_i) |=> (col_o || full_duplex_i || sqe_inhibit_i));

  assert_sqe_inhibit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sqe_inhibit_i && !(rx_act && tx_en_i)) |-> !col_o);
endmodule

bind crs_col_gen crs_col_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .full_duplex_i (full_duplex_i),
  .repeater_i    (repeater_i),
  .tx_en_i       (tx_en_i),
  .sqe_req_i     (sqe_req_i),
  .sqe_inhibit_i (sqe_inhibit_i),
  .crs_o         (crs_o),
  .col_o         (col_o),
  .rx_act        (rx_act),
  .act100        (act100),
  .win_idle      (win_idle)
);

// File: tb/crs_col_gen_tb_top.sv
`timescale 1ns/1ps
module crs_col_gen_tb_top;
  localparam int unsigned W   = 10;
  localparam int unsigned LEN = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic speed100, cbit, cvld, rx10, tx_en, fdx, rep, sqe_req, sqe_inh;
  logic crs, col;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  crs_col_gen #(.WIN_W(W), .SQE_LEN(LEN)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .speed100_i (speed100),
    .code_bit_i (cbit), .code_bit_vld_i (cvld), .rx_act10_i (rx10),
    .tx_en_i (tx_en), .full_duplex_i (fdx), .repeater_i (rep),
    .sqe_req_i (sqe_req), .sqe_inhibit_i (sqe_inh),
    .crs_o (crs), .col_o (col)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic shift_bits(input logic [W-1:0] p);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      cbit = p[i];
      cvld = 1'b1;
    end
    @(negedge clk);
    cvld = 1'b0;
  endtask

  function automatic logic exp_act(input logic [W-1:0] p);
    logic [W-1:0] z;
    int nz;
    z  = ~p;
    nz = $countones(z);
    return (nz >= 3) || (nz == 2 && ((z & (z >> 1)) == '0));
  endfunction

  task automatic flush();
    shift_bits('1);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    speed100 = 1'b1; cbit = 1'b1; cvld = 1'b0; rx10 = 1'b0; tx_en = 1'b0;
    fdx = 1'b1; rep = 1'b0; sqe_req = 1'b0; sqe_inh = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 crs in reset", crs, 1'b0);
    check("R1 col in reset", col, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 crs after reset", crs, 1'b0);
    check("R1 col after reset", col, 1'b0);

    // R4: in 100 Mb/s mode the 10 Mb/s input is ignored
    rx10 = 1'b1;
    @(negedge clk);
    check("R4 rx10 ignored at 100M", crs, 1'b0);
    rx10 = 1'b0;

    // R2: exhaustive window sweep, full duplex so crs = activity
    for (int p = 0; p < (1 << W); p++) begin
      shift_bits(W'(p));
      @(negedge clk);
      check($sformatf("R2 window %b", W'(p)), crs, exp_act(W'(p)));
      flush();
      if (crs !== 1'b0) check("R3 flush clears", crs, 1'b0);
    end

    // R3: hold until idle window, drop one clock later
    shift_bits('0);
    @(negedge clk);
    check("R3 active on zeros", crs, 1'b1);
    for (int i = 0; i < W - 1; i++) begin
      @(negedge clk); cbit = 1'b1; cvld = 1'b1;
    end
    @(negedge clk); cvld = 1'b0;
    @(negedge clk);
    check("R3 held with one zero left", crs, 1'b1);
    cbit = 1'b1; cvld = 1'b1;
    @(negedge clk); cvld = 1'b0;
    check("R3 still high as idle forms", crs, 1'b1);
    @(negedge clk);
    check("R3 drops after idle window", crs, 1'b0);

    // R4..R8: mode table at 10 Mb/s
    speed100 = 1'b0;
    for (int m = 0; m < 16; m++) begin
      logic r, t, f, q, ecrs, ecol;
      {r, t, f, q} = 4'(m);
      @(negedge clk);
      rx10 = r; tx_en = t; fdx = f; rep = q;
      @(negedge clk);
      ecrs = r | (t & ~f & ~q);
      ecol = ~f & r & t;
      if (!t) check($sformatf("R4 crs follows rx10 m=%0d", m), crs, ecrs);
      else if (f || q) check($sformatf("R6 crs m=%0d", m), crs, ecrs);
      else check($sformatf("R5 crs m=%0d", m), crs, ecrs);
      if (f) check($sformatf("R8 col m=%0d", m), col, ecol);
      else check($sformatf("R7 col m=%0d", m), col, ecol);
    end

    // R9: SQE pulse length in half duplex
    @(negedge clk);
    rx10 = 1'b0; tx_en = 1'b0; fdx = 1'b0; rep = 1'b0; sqe_inh = 1'b0;
    @(negedge clk); sqe_req = 1'b1;
    @(negedge clk); sqe_req = 1'b0;
    check("R9 pulse starts", col, 1'b1);
    n = 0;
    repeat (LEN + 4) begin
      if (col) n++;
      @(negedge clk);
    end
    check($sformatf("R9 pulse length %0d", n), (n == LEN), 1'b1);

    // R10: inhibited pulse
    sqe_inh = 1'b1;
    @(negedge clk); sqe_req = 1'b1;
    @(negedge clk); sqe_req = 1'b0;
    n = 0;
    repeat (LEN + 4) begin
      if (col) n++;
      @(negedge clk);
    end
    check($sformatf("R10 inhibited pulse count %0d", n), (n == 0), 1'b1);
    sqe_inh = 1'b0;

    // R8: request in full duplex is dropped, not remembered
    fdx = 1'b1;
    @(negedge clk); sqe_req = 1'b1;
    @(negedge clk); sqe_req = 1'b0;
    check("R8 no col in full duplex", col, 1'b0);
    fdx = 1'b0;
    n = 0;
    repeat (LEN + 4) begin
      @(negedge clk);
      if (col) n++;
    end
    check($sformatf("R8 dropped request count %0d", n), (n == 0), 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule